// File: doc/BRIEF.md
# PCI Main-Memory Chip-Select Decoder

This block sits beside a PCI bus and watches every transaction start. When FRAME# goes active, it captures the address and command. One clock later it decides whether the cycle targets main memory. A host CPU bridge uses the resulting active-low, one-clock select pulse to claim the cycle and forward it to its memory controller.

A cycle is claimed only when all of the following hold:
- decoding is enabled;
- the command is one of the memory commands;
- the address is strictly below a programmable top-of-memory value;
- the address lies outside an optional programmable hole.

The configuration values are plain input ports. The block does no data-phase tracking and no target-response signalling. It has no stream interface, so every pin is a plain control or data pin with no back-pressure.

Top module: `pci_memsel_decoder`

## Requirements
- R1: An address phase is the rising edge at which `frame_n` is sampled 0 and the previous sample was 1. `ad` and `cbe_n` are captured on that edge. `frame_n` must be seen high at least once after reset before the first phase counts.
- R2: For an address phase at edge k that hits, `memsel_n` is 0 from edge k+1 until edge k+2. It is 1 in the cycle between edge k and edge k+1.
- R3: `memsel_n` is never 0 for two consecutive clock cycles, and it never goes low except as the result of an address phase.
- R4: While `rst_n` is 0, `memsel_n` is 1.
- R5: These command codes on `cbe_n` can hit: 4'b0110 (memory read), 4'b0111 (memory write), 4'b1100 (read multiple), 4'b1110 (read line) and 4'b1111 (write and invalidate).
- R6: All other command codes never produce a pulse. This includes I/O 4'b0010/4'b0011, configuration 4'b1010/4'b1011 and reserved codes.
- R7: When `cfg_enable` is 0, no pulse is produced.
- R8: A hit requires the address to be unsigned-less-than `cfg_top`. An address equal to `cfg_top` misses.
- R9: When `cfg_hole_en` is 1, addresses with `cfg_hole_lo <= addr <= cfg_hole_hi` miss; both bounds are inclusive. When `cfg_hole_en` is 0, the hole bounds have no effect.
- R10: Address phases two edges apart each produce their own pulse. A `frame_n` held low across several edges is one phase and gives at most one pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCI clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_n | input | 1 | Bus FRAME#, active low |
| ad | input | ADDR_W | Address/data bus |
| cbe_n | input | 4 | Command/byte-enable bus |
| cfg_enable | input | 1 | Decode enable |
| cfg_top | input | ADDR_W | Top of memory (exclusive) |
| cfg_hole_en | input | 1 | Hole enable |
| cfg_hole_lo | input | ADDR_W | Hole lower bound (inclusive) |
| cfg_hole_hi | input | ADDR_W | Hole upper bound (inclusive) |
| memsel_n | output | 1 | Memory chip-select, one-clock active-low pulse |

## Verification
Suppose the bench drives FRAME# low just after rising edge n, so the address phase is edge n+1. The select result then belongs to the cycle after edge n+2, and the select must be back high after edge n+3. For every phase, the driver queues three expected samples: high at n+1, the decoded value at n+2, and high at n+3. The monitor samples on the falling edge and compares each queued item in the cycle it names. Any low sample that no queued item claims is reported as an unexpected pulse, which covers held-FRAME and back-to-back cases.

// File: rtl/pms_pkg.sv
`timescale 1ns/1ps
package pms_pkg;
  localparam int CMD_W = 4;

  typedef enum logic [CMD_W-1:0] {
    CMD_IO_RD   = 4'b0010,
    CMD_IO_WR   = 4'b0011,
    CMD_MEM_RD  = 4'b0110,
    CMD_MEM_WR  = 4'b0111,
    CMD_CFG_RD  = 4'b1010,
    CMD_CFG_WR  = 4'b1011,
    CMD_MEM_RDM = 4'b1100,
    CMD_MEM_RDL = 4'b1110,
    CMD_MEM_WRI = 4'b1111
  } pci_cmd_e;

  function automatic logic is_mem_cmd(input logic [CMD_W-1:0] c);
    case (c)
      CMD_MEM_RD, CMD_MEM_WR, CMD_MEM_RDM,
      CMD_MEM_RDL, CMD_MEM_WRI: is_mem_cmd = 1'b1;
      default:                  is_mem_cmd = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/pms_phase_capture.sv
`timescale 1ns/1ps
module pms_phase_capture #(
  parameter int ADDR_W = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      frame_n,
  input  logic [ADDR_W-1:0]         ad,
  input  logic [pms_pkg::CMD_W-1:0] cbe_n,
  output logic                      phase_vld,
  output logic [ADDR_W-1:0]         phase_addr,
  output logic [pms_pkg::CMD_W-1:0] phase_cmd
);
  logic frame_seen_hi;
  logic start;

  assign start = frame_seen_hi && !frame_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_seen_hi <= 1'b0;
      phase_vld     <= 1'b0;
      phase_addr    <= '0;
      phase_cmd     <= '0;
    end else begin
      frame_seen_hi <= frame_n;
      phase_vld     <= start;
      if (start) begin
        phase_addr <= ad;
        phase_cmd  <= cbe_n;
      end
    end
  end

  // R1: a phase needs a high sample before it, so two never touch
  assert_phase_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
    phase_vld |=> !phase_vld);
endmodule

// File: rtl/pms_window_check.sv
`timescale 1ns/1ps
module pms_window_check #(
  parameter int ADDR_W   = 32,
  parameter bit HAS_HOLE = 1'b1
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] top,
  input  logic              hole_en,
  input  logic [ADDR_W-1:0] hole_lo,
  input  logic [ADDR_W-1:0] hole_hi,
  output logic              below_top,
  output logic              in_hole
);
  assign below_top = (addr < top);

  generate
    if (HAS_HOLE) begin : g_hole
      assign in_hole = hole_en && (addr >= hole_lo) && (addr <= hole_hi);
    end else begin : g_nohole
      logic unused_hole;
      assign unused_hole = ^{hole_en, hole_lo, hole_hi};
      assign in_hole     = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/pms_cmd_filter.sv
`timescale 1ns/1ps
module pms_cmd_filter (
  input  logic [pms_pkg::CMD_W-1:0] cmd,
  output logic                      mem_cmd
);
  assign mem_cmd = pms_pkg::is_mem_cmd(cmd);
endmodule

// File: rtl/pci_memsel_decoder.sv
`timescale 1ns/1ps
module pci_memsel_decoder #(
  parameter int ADDR_W   = 32,
  parameter bit HAS_HOLE = 1'b1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      frame_n,
  input  logic [ADDR_W-1:0]         ad,
  input  logic [pms_pkg::CMD_W-1:0] cbe_n,
  input  logic                      cfg_enable,
  input  logic [ADDR_W-1:0]         cfg_top,
  input  logic                      cfg_hole_en,
  input  logic [ADDR_W-1:0]         cfg_hole_lo,
  input  logic [ADDR_W-1:0]         cfg_hole_hi,
  output logic                      memsel_n
);
  logic                      phase_vld;
  logic [ADDR_W-1:0]         phase_addr;
  logic [pms_pkg::CMD_W-1:0] phase_cmd;
  logic                      mem_cmd;
  logic                      below_top;
  logic                      in_hole;
  logic                      hit;

  pms_phase_capture #(.ADDR_W(ADDR_W)) u_capture (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .ad(ad), .cbe_n(cbe_n),
    .phase_vld(phase_vld), .phase_addr(phase_addr), .phase_cmd(phase_cmd)
  );

  pms_cmd_filter u_filter (.cmd(phase_cmd), .mem_cmd(mem_cmd));

  pms_window_check #(.ADDR_W(ADDR_W), .HAS_HOLE(HAS_HOLE)) u_window (
    .addr(phase_addr), .top(cfg_top), .hole_en(cfg_hole_en),
    .hole_lo(cfg_hole_lo), .hole_hi(cfg_hole_hi),
    .below_top(below_top), .in_hole(in_hole)
  );

  assign hit = phase_vld && cfg_enable && mem_cmd && below_top && !in_hole;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) memsel_n <= 1'b1;
    else        memsel_n <= !hit;
  end

  // R4: held inactive through reset
  always @(negedge clk) begin
    if (!rst_n) assert_reset_high_R4: assert (memsel_n === 1'b1);
  end

  assert_one_clock_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !memsel_n |=> memsel_n);

  assert_pulse_origin_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !memsel_n |-> $past(phase_vld));

  assert_non_mem_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_vld && !mem_cmd) |=> memsel_n);

  assert_disabled_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_vld && !cfg_enable) |=> memsel_n);

  assert_above_top_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_vld && !below_top) |=> memsel_n);

  assert_hole_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_vld && in_hole) |=> memsel_n);
endmodule

// File: tb/pci_memsel_decoder_test.sv
`timescale 1ns/1ps
module pci_memsel_decoder_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        frame_n;
  logic [31:0] ad;
  logic [3:0]  cbe_n;
  logic        cfg_enable, cfg_hole_en;
  logic [31:0] cfg_top, cfg_hole_lo, cfg_hole_hi;
  logic        memsel_n;

  int tests = 0;
  int fails = 0;
  int cyc   = 0;
  bit done  = 0;

  typedef struct { int at; bit low; string req; } exp_t;
  exp_t sb[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pci_memsel_decoder uut (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .ad(ad), .cbe_n(cbe_n),
    .cfg_enable(cfg_enable), .cfg_top(cfg_top), .cfg_hole_en(cfg_hole_en),
    .cfg_hole_lo(cfg_hole_lo), .cfg_hole_hi(cfg_hole_hi), .memsel_n(memsel_n)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic act, input logic expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0b expected=%0b (cycle %0d)", req, what, act, expv, cyc);
    end
  endtask

  // Driver: one address phase; FRAME# held low for 'hold' clocks
  task automatic phase(input logic [31:0] a, input logic [3:0] c,
                       input int hold, input bit hit, input string req);
    int n;
    @(negedge clk);
    n = cyc;
    frame_n = 1'b0; ad = a; cbe_n = c;
    sb.push_back('{n + 1, 1'b0, req});
    sb.push_back('{n + 2, hit,  req});
    sb.push_back('{n + 3, 1'b0, req});
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      ad = ~a; cbe_n = 4'b0110;
    end
    frame_n = 1'b1;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    bit claimed;
    exp_t e;
    claimed = 1'b0;
    if (rst_n) begin
      while (sb.size() > 0 && sb[0].at == cyc) begin
        e = sb.pop_front();
        check(memsel_n === !e.low, e.req, "memsel_n", memsel_n, !e.low);
        if (e.low) claimed = 1'b1;
      end
      if (memsel_n === 1'b0 && !claimed)
        check(1'b0, "R3/R10", "unexpected pulse", memsel_n, 1'b1);
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; frame_n = 1'b1; ad = '0; cbe_n = 4'b0000;
    cfg_enable = 1'b1; cfg_top = 32'h4000_0000;
    cfg_hole_en = 1'b1; cfg_hole_lo = 32'h000A_0000; cfg_hole_hi = 32'h000F_FFFF;
    // R4: inactive during reset, even with FRAME# low
    @(negedge clk); frame_n = 1'b0; ad = 32'h100; cbe_n = 4'b0110;
    repeat (3) begin
      @(negedge clk);
      check(memsel_n === 1'b1, "R4", "memsel_n in reset", memsel_n, 1'b1);
    end
    frame_n = 1'b1;
    @(negedge clk); rst_n = 1'b1;
    settle();

    // R1 R2 R5: every memory command hits
    phase(32'h0000_1000, 4'b0110, 1, 1, "R2 R5 mem read");
    phase(32'h0010_0000, 4'b0111, 1, 1, "R5 mem write");
    phase(32'h0200_0040, 4'b1100, 1, 1, "R5 read multiple");
    phase(32'h0300_0080, 4'b1110, 1, 1, "R5 read line");
    phase(32'h3FFF_FFC0, 4'b1111, 1, 1, "R5 write invalidate");
    settle();
    // R6: non-memory commands never select
    phase(32'h0000_1000, 4'b0010, 1, 0, "R6 io read");
    phase(32'h0000_1000, 4'b0011, 1, 0, "R6 io write");
    phase(32'h0000_1000, 4'b1010, 1, 0, "R6 cfg read");
    phase(32'h0000_1000, 4'b1011, 1, 0, "R6 cfg write");
    phase(32'h0000_1000, 4'b0100, 1, 0, "R6 reserved");
    settle();
    // R8: top-of-memory boundary
    phase(32'h3FFF_FFFF, 4'b0110, 1, 1, "R8 top-1");
    phase(32'h4000_0000, 4'b0110, 1, 0, "R8 equal top");
    phase(32'hF000_0000, 4'b0111, 1, 0, "R8 above top");
    settle();
    // R9: hole bounds inclusive
    phase(32'h0009_FFFF, 4'b0110, 1, 1, "R9 below hole");
    phase(32'h000A_0000, 4'b0110, 1, 0, "R9 hole low bound");
    phase(32'h000C_0000, 4'b0110, 1, 0, "R9 hole middle");
    phase(32'h000F_FFFF, 4'b0110, 1, 0, "R9 hole high bound");
    phase(32'h0010_0000, 4'b0110, 1, 1, "R9 above hole");
    settle();
    cfg_hole_en = 1'b0;
    phase(32'h000C_0000, 4'b0110, 1, 1, "R9 hole disabled");
    settle();
    cfg_hole_en = 1'b1;
    // R7: decode disabled
    cfg_enable = 1'b0;
    phase(32'h0000_2000, 4'b0110, 1, 0, "R7 disabled");
    settle();
    cfg_enable = 1'b1;
    // R10: back-to-back and held FRAME#
    phase(32'h0000_3000, 4'b0110, 1, 1, "R10 b2b first");
    phase(32'h000B_0000, 4'b0110, 1, 0, "R10 b2b miss");
    phase(32'h0000_5000, 4'b0111, 1, 1, "R10 b2b third");
    phase(32'h0000_6000, 4'b1110, 1, 1, "R10 b2b fourth");
    settle();
    phase(32'h0000_7000, 4'b0110, 5, 1, "R10 held frame");
    settle();
    settle();
    check(sb.size() == 0, "R2", "scoreboard drained", sb.size() == 0, 1'b1);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule